// File: doc/BRIEF.md
# SCSI Initiator DMA Byte Handshake

This block moves single bytes between a DMA port and the SCSI bus for the initiator side, one REQ/ACK handshake per byte. In the receive direction it waits for the target to raise REQ. After a programmable settle delay it captures the bus byte, raises DRQ and asserts ACK. It then follows REQ back low. ACK stays asserted until the DMA engine reads the byte. That read releases ACK and arms reception of the next byte.

In the send direction, a start command raises DRQ. Each DMA write puts its byte on the bus together with ACK and holds both for the settle delay. The block then keeps them until REQ is low, releases the bus and raises DRQ for the next byte.

A small configuration port sets the DMA enable, the initiator flag and the settle period, and issues the two start commands. Clearing the enable aborts any handshake in progress. So does a loss of BSY while the initiator flag is set.

Top module: `scsi_dma_handshake`

## Requirements
- R1: After reset, ACK, data drive enable, DRQ and the overrun flag are low, and the settle period is 5 clocks.
- R2: The configuration port has these offsets: 0 is control (bit 0 DMA enable, bit 1 initiator flag), 1 is the settle period, 2 starts a send and 3 starts a receive. A write to offset 3 with DMA enabled arms reception. Once armed, the block registers REQ high at a clock edge. Exactly P further edges later, with settle period P, it captures the bus byte, raises DRQ and asserts ACK.
- R3: After capture, the block waits for REQ low and keeps ACK asserted. A DMA read while DRQ is high returns the captured byte, drops DRQ and releases ACK at the next edge. With DMA still enabled, it re-arms reception without a new start command.
- R4: A write to offset 2 while the block is idle and DMA is enabled raises DRQ at the same edge.
- R5: A DMA write while DRQ is high drops DRQ and drives its byte with the data drive enable and ACK asserted. When REQ is already low, ACK stays high for exactly P+1 clocks.
- R6: After the settle delay of a send, ACK and the data drive stay asserted for as long as REQ is high. They are released at the first edge that sees REQ low, and DRQ rises at that same edge.
- R7: The settle period is written at offset 1, and a value of 0 behaves as 1.
- R8: A DMA read or write while DRQ is low has no effect on ACK, DRQ or the bus drive. It sets an overrun flag that stays set until reset.
- R9: When DMA enable is cleared, the edge after the one that clears it releases ACK and the data drive, drops DRQ and returns the sequencer to idle. After re-enabling, REQ alone starts nothing.
- R10: With the initiator flag set, BSY low aborts the sequence at the next edge, as R9 describes. With the flag clear, BSY is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration offset |
| cfg_wdata | input | DATA_W | Configuration write data |
| scsi_req_i | input | 1 | REQ from the target |
| scsi_bsy_i | input | 1 | BSY sensed on the bus |
| scsi_data_i | input | DATA_W | Bus data sensed |
| scsi_ack_o | output | 1 | ACK driven to the bus |
| scsi_data_o | output | DATA_W | Bus data to drive |
| scsi_data_oe_o | output | 1 | Bus data drive enable |
| dma_rd_i | input | 1 | DMA read strobe |
| dma_wr_i | input | 1 | DMA write strobe |
| dma_wdata_i | input | DATA_W | DMA write byte |
| dma_rdata_o | output | DATA_W | Captured receive byte |
| drq_o | output | 1 | DMA request |
| overrun_o | output | 1 | Sticky flag for accesses made while DRQ was low |

## Verification
The hardest situation to reach is an abort while a sent byte is still on the bus with ACK up. Normally that window closes after a few clocks. The stimulus keeps REQ high through a DMA write, which holds ACK and the data drive asserted indefinitely. It then clears the enable or drops BSY inside that window and checks the exact cycle of release. Receive latencies are measured edge by edge from the cycle REQ rises, under three settle values including zero.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_RX_WREQ1,
    HS_RX_SETTLE,
    HS_RX_WREQ0,
    HS_TX_SETTLE,
    HS_TX_WREQ0
  } hs_state_e;

  // configuration offsets
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_SETTLE   = 1;
  localparam int unsigned REG_GO_SEND  = 2;
  localparam int unsigned REG_GO_RECV  = 3;

  // control bit positions
  localparam int unsigned CTRL_DMA_BIT  = 0;
  localparam int unsigned CTRL_INIT_BIT = 1;

endpackage

// File: rtl/scsi_hs_regs.sv
module scsi_hs_regs
  import scsi_hs_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_W   = 8,
  parameter int SETTLE_RST = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic                dma_en,
  output logic                init_mode,
  output logic [SETTLE_W-1:0] settle,
  output logic                go_send,
  output logic                go_recv
);

  logic wr_ctrl, wr_settle;

  assign wr_ctrl   = cfg_wr && (cfg_addr == ADDR_W'(REG_CTRL));
  assign wr_settle = cfg_wr && (cfg_addr == ADDR_W'(REG_SETTLE));
  assign go_send   = cfg_wr && (cfg_addr == ADDR_W'(REG_GO_SEND));
  assign go_recv   = cfg_wr && (cfg_addr == ADDR_W'(REG_GO_RECV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en    <= 1'b0;
      init_mode <= 1'b0;
      settle    <= SETTLE_W'(SETTLE_RST);
    end else begin
      if (wr_ctrl) begin
        dma_en    <= cfg_wdata[CTRL_DMA_BIT];
        init_mode <= cfg_wdata[CTRL_INIT_BIT];
      end
      if (wr_settle) settle <= cfg_wdata[SETTLE_W-1:0];
    end
  end

  // R1: reset value of the settle period
  p_settle_reset_r1: assert property (@(posedge clk)
    !rst_n |=> settle == SETTLE_W'(SETTLE_RST));

endmodule

// File: rtl/scsi_hs_settle.sv
module scsi_hs_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] period,
  output logic                done
);

  logic [SETTLE_W-1:0] cnt;

  // a period of zero is promoted to one clock
  function automatic logic [SETTLE_W-1:0] settle_norm(input logic [SETTLE_W-1:0] p);
    return (p == '0) ? SETTLE_W'(1) : p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= settle_norm(period);
    else if (cnt != '0)   cnt <= cnt - SETTLE_W'(1);
  end

  assign done = (cnt == SETTLE_W'(1));

  // R7: load takes the normalised period
  p_settle_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == settle_norm($past(period)));

  // R7: done is a single-cycle event unless reloaded
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !done);

endmodule

// File: rtl/scsi_hs_fsm.sv
module scsi_hs_fsm
  import scsi_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              init_mode,
  input  logic              go_send,
  input  logic              go_recv,
  input  logic              req_i,
  input  logic              bsy_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              dma_rd,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              settle_done,
  output logic              settle_load,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              drq_o,
  output logic              overrun_o,
  output logic [DATA_W-1:0] rx_byte
);

  hs_state_e state;

  // named internal events
  logic abort, rd_ok, wr_ok, stray;

  assign abort = !dma_en || (init_mode && !bsy_i);
  assign rd_ok = dma_rd && drq_o;
  assign wr_ok = dma_wr && drq_o && !dma_rd;
  assign stray = (dma_rd || dma_wr) && !drq_o;

  assign settle_load = ((state == HS_RX_WREQ1) && req_i) || wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= HS_IDLE;
      ack_o     <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
      drq_o     <= 1'b0;
      overrun_o <= 1'b0;
      rx_byte   <= '0;
    end else begin
      if (stray) overrun_o <= 1'b1;
      if (abort) begin
        state     <= HS_IDLE;
        ack_o     <= 1'b0;
        data_oe_o <= 1'b0;
        drq_o     <= 1'b0;
      end else begin
        unique case (state)
          HS_RX_WREQ1: if (req_i) state <= HS_RX_SETTLE;
          HS_RX_SETTLE: if (settle_done) begin
            rx_byte <= bus_data_i;
            drq_o   <= 1'b1;
            ack_o   <= 1'b1;
            state   <= HS_RX_WREQ0;
          end
          HS_RX_WREQ0: if (!req_i) state <= HS_IDLE;
          HS_TX_SETTLE: if (settle_done) state <= HS_TX_WREQ0;
          HS_TX_WREQ0: if (!req_i) begin
            ack_o     <= 1'b0;
            data_oe_o <= 1'b0;
            drq_o     <= 1'b1;
            state     <= HS_IDLE;
          end
          default: ;
        endcase
        if (go_send && state == HS_IDLE) drq_o <= 1'b1;
        if (go_recv && state == HS_IDLE) state <= HS_RX_WREQ1;
        if (rd_ok) begin
          drq_o <= 1'b0;
          ack_o <= 1'b0;
          state <= HS_RX_WREQ1;
        end else if (wr_ok) begin
          drq_o     <= 1'b0;
          data_o    <= dma_wdata;
          data_oe_o <= 1'b1;
          ack_o     <= 1'b1;
          state     <= HS_TX_SETTLE;
        end
      end
    end
  end

  p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> !ack_o && !drq_o);

  p_wr_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !abort |=> ack_o && data_oe_o && !drq_o);

  p_oe_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> ack_o);

  p_hold_while_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == HS_TX_WREQ0 && req_i && !abort |=> ack_o && data_oe_o);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  p_stray_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stray |=> overrun_o);

  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !ack_o && !data_oe_o && !drq_o && state == HS_IDLE);

  p_bsy_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode && !bsy_i |=> state == HS_IDLE && !ack_o);

endmodule

// File: rtl/scsi_dma_handshake.sv
module scsi_dma_handshake #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_W   = 8,
  parameter int SETTLE_RST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              scsi_req_i,
  input  logic              scsi_bsy_i,
  input  logic [DATA_W-1:0] scsi_data_i,
  output logic              scsi_ack_o,
  output logic [DATA_W-1:0] scsi_data_o,
  output logic              scsi_data_oe_o,
  input  logic              dma_rd_i,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic [DATA_W-1:0] dma_rdata_o,
  output logic              drq_o,
  output logic              overrun_o
);

  logic                dma_en, init_mode, go_send, go_recv;
  logic                settle_load, settle_done;
  logic [SETTLE_W-1:0] settle;

  scsi_hs_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dma_en(dma_en), .init_mode(init_mode), .settle(settle),
    .go_send(go_send), .go_recv(go_recv)
  );

  scsi_hs_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .period(settle), .done(settle_done)
  );

  scsi_hs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .init_mode(init_mode),
    .go_send(go_send), .go_recv(go_recv), .req_i(scsi_req_i), .bsy_i(scsi_bsy_i),
    .bus_data_i(scsi_data_i), .dma_rd(dma_rd_i), .dma_wr(dma_wr_i),
    .dma_wdata(dma_wdata_i), .settle_done(settle_done), .settle_load(settle_load),
    .ack_o(scsi_ack_o), .data_o(scsi_data_o), .data_oe_o(scsi_data_oe_o),
    .drq_o(drq_o), .overrun_o(overrun_o), .rx_byte(dma_rdata_o)
  );

endmodule

// File: tb/scsi_dma_handshake_tb.sv
module scsi_dma_handshake_tb;

  logic       clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       req = 1'b0, bsy = 1'b1;
  logic [7:0] scsi_data_i = '0;
  logic       ack, oe, drq, ovr;
  logic [7:0] scsi_data_o, dma_rdata;
  logic       dma_rd = 1'b0, dma_wr = 1'b0;
  logic [7:0] dma_wdata = '0;

  int n_vec = 0, n_bad = 0, mon_vec = 0, mon_bad = 0;

  // expected sent bytes: filled by the driver, drained by the monitor
  logic [7:0] exp_tx [0:15];
  int tx_wr = 0;
  int tx_rd = 0;

  scsi_dma_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .scsi_req_i(req), .scsi_bsy_i(bsy), .scsi_data_i(scsi_data_i),
    .scsi_ack_o(ack), .scsi_data_o(scsi_data_o), .scsi_data_oe_o(oe),
    .dma_rd_i(dma_rd), .dma_wr_i(dma_wr), .dma_wdata_i(dma_wdata),
    .dma_rdata_o(dma_rdata), .drq_o(drq), .overrun_o(ovr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic tgt_rx(input logic [7:0] b, input int lat, input string rq);
    int n = 0;
    @(negedge clk); scsi_data_i = b; req = 1'b1;
    while (n < 60) begin
      @(negedge clk); n++;
      if (ack) break;
    end
    chk(rq, n, lat);
    chk("R2 drq raised on capture", drq, 1);
    req = 1'b0; scsi_data_i = ~b;
    @(negedge clk);
    chk("R3 ack held until dma read", ack, 1);
  endtask

  task automatic dma_read(input logic [7:0] b);
    @(negedge clk);
    chk("R3 read returns captured byte", dma_rdata, b);
    dma_rd = 1'b1;
    @(negedge clk); dma_rd = 1'b0;
    chk("R3 ack released by read", ack, 0);
    chk("R3 drq dropped by read", drq, 0);
  endtask

  task automatic dma_write(input logic [7:0] b);
    exp_tx[tx_wr % 16] = b; tx_wr++;
    @(negedge clk); dma_wr = 1'b1; dma_wdata = b;
    @(negedge clk); dma_wr = 1'b0;
  endtask

  // monitor: compares each byte put on the bus against the expected list
  logic ack_q = 1'b0;
  always @(negedge clk) begin
    if (ack && oe && !ack_q) begin
      mon_vec++;
      if (tx_rd >= tx_wr || scsi_data_o != exp_tx[tx_rd % 16]) begin
        mon_bad++;
        $display("FAIL R5 sent byte: actual %0h expected %0h", scsi_data_o, exp_tx[tx_rd % 16]);
      end
      tx_rd++;
    end
    ack_q = ack;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + mon_vec + 1, n_bad + mon_bad + 1);
    $finish;
  end

  initial begin
    int n;
    logic held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", ack, 0);
    chk("R1 oe after reset", oe, 0);
    chk("R1 drq after reset", drq, 0);
    chk("R1 overrun after reset", ovr, 0);

    // R8: accesses with DRQ low
    dma_rd = 1'b1; @(negedge clk); dma_rd = 1'b0;
    chk("R8 stray read sets overrun", ovr, 1);
    chk("R8 stray read leaves drq", drq, 0);
    dma_wr = 1'b1; dma_wdata = 8'hFF; @(negedge clk); dma_wr = 1'b0;
    @(negedge clk);
    chk("R8 stray write drives nothing", oe, 0);
    chk("R8 stray write leaves ack", ack, 0);

    // receive
    reg_write(2'd0, 8'h01);
    reg_write(2'd3, 8'h00);
    tgt_rx(8'hA5, 6, "R1 R2 default settle latency");
    dma_read(8'hA5);
    tgt_rx(8'h3C, 6, "R3 rearmed receive latency");
    dma_read(8'h3C);
    reg_write(2'd1, 8'h02);
    tgt_rx(8'h81, 3, "R7 settle 2 latency");
    dma_read(8'h81);
    reg_write(2'd1, 8'h00);
    tgt_rx(8'h7E, 2, "R7 settle zero latency");
    dma_read(8'h7E);

    // back to idle, settle 3
    reg_write(2'd0, 8'h00);
    reg_write(2'd0, 8'h01);
    reg_write(2'd1, 8'h03);

    // send
    reg_write(2'd2, 8'h00);
    chk("R4 start send raises drq", drq, 1);
    dma_write(8'h11);
    n = 0;
    while (ack && n < 60) begin n++; @(negedge clk); end
    chk("R5 ack high for settle+1", n, 4);
    chk("R6 data released", oe, 0);
    chk("R6 drq for next byte", drq, 1);

    // REQ held high keeps the byte on the bus
    req = 1'b1;
    dma_write(8'h22);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(ack && oe)) held = 1'b0;
    end
    chk("R6 held while REQ high", held, 1);
    req = 1'b0;
    @(negedge clk);
    chk("R6 ack released on REQ low", ack, 0);
    chk("R6 oe released on REQ low", oe, 0);
    chk("R6 drq raised on REQ low", drq, 1);

    // R9 abort with ACK up
    req = 1'b1;
    dma_write(8'h33);
    repeat (2) @(negedge clk);
    reg_write(2'd0, 8'h00);
    chk("R9 ack still up one clock", ack, 1);
    @(negedge clk);
    chk("R9 abort releases ack", ack, 0);
    chk("R9 abort releases oe", oe, 0);
    chk("R9 abort drops drq", drq, 0);
    req = 1'b0;
    reg_write(2'd0, 8'h01);
    req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 idle after abort ack", ack, 0);
    chk("R9 idle after abort drq", drq, 0);
    req = 1'b0;

    // R10 BSY loss with initiator flag
    reg_write(2'd0, 8'h03);
    reg_write(2'd2, 8'h00);
    chk("R4 start send with initiator flag", drq, 1);
    req = 1'b1;
    dma_write(8'h44);
    @(negedge clk);
    bsy = 1'b0;
    @(negedge clk);
    chk("R10 bsy loss releases ack", ack, 0);
    chk("R10 bsy loss releases oe", oe, 0);
    chk("R10 bsy loss drops drq", drq, 0);
    bsy = 1'b1; req = 1'b0;

    // R10 BSY ignored without initiator flag
    reg_write(2'd0, 8'h01);
    bsy = 1'b0;
    reg_write(2'd3, 8'h00);
    tgt_rx(8'hC3, 4, "R10 bsy ignored without initiator flag");
    dma_read(8'hC3);
    bsy = 1'b1;

    chk("R5 every sent byte observed", tx_rd, tx_wr);
    chk("R8 overrun still set", ovr, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec + mon_vec, n_bad + mon_bad);
    $finish;
  end

endmodule